// File: doc/BRIEF.md
# Descriptor-Chained DMA Output Channel

This block is one memory-to-stream DMA channel. Software points it at a linked list of four-word data descriptors in memory and tells it to start. For each descriptor the channel reads the buffer bytes from the current buffer position up to, but not including, the descriptor's end pointer. It sends them one byte per beat on a valid/ready output stream, and it flags the final beat as end of packet when the descriptor asks for that. It then writes the descriptor back to where it was read from, raises an interrupt if the descriptor requests one, and moves on to the next descriptor. When it completes a descriptor marked end-of-list, it stalls. A later continue command re-reads that same descriptor. If software has since cleared the end-of-list flag, the channel follows the descriptor's next pointer and carries on.

Software reaches the channel through a 32-bit register window. The descriptor pointer and the buffer position are kept in two separate registers. Memory is reached through a single-word request/acknowledge port. The stream rules are as follows. A beat transfers on a clock edge where `st_valid` and `st_ready` are both high. Once `st_valid` rises it stays high, and `st_data` and `st_last` stay unchanged, until that beat transfers. `st_ready` may be held low for any length of time, and the channel simply waits.

Top module: `dmaout_chan`

## Requirements
- R1: Registers are reached by full-word accesses (`reg_size` = 2) at these byte offsets: descriptor pointer 0x58, buffer position 0x5C, command 0x80, state 0x88, interrupt mask 0x8C, interrupt acknowledge 0x90, raw interrupt 0x94, masked interrupt 0x98. Every other offset reads as zero. A read returns its data on `reg_rdata` one cycle after the request. An access with any other size raises `reg_err` one cycle later and has no effect.
- R2: Writing the command register with bit 0 set, while the channel is idle (state 0) or stalled (state 2), starts the channel. It reads the four descriptor words at the descriptor pointer: word 0 is the next pointer, word 1 is buf, word 2 holds the flags, and word 3 is the end pointer. A command holding only bit 2 (load context) does not start the channel and makes no memory request.
- R3: The bytes sent for a descriptor are the memory bytes at addresses from the buffer position register up to the end pointer minus one, in ascending order. Within each 32-bit word the lowest byte is at bit 7:0. When the end pointer is less than or equal to the buffer position, no bytes are sent. After the last byte, the buffer position equals the end pointer.
- R4: `st_data` and `st_last` hold steady while `st_valid` is high and `st_ready` is low. `st_last` is high only on the final byte of a descriptor whose flags word has bit 4 set.
- R5: After its data, every descriptor is written back as four words to the address it was read from, with its contents unchanged.
- R6: After a descriptor whose end-of-list bit (flags bit 0) is clear, the descriptor pointer takes that descriptor's next pointer. The next descriptor is then read, and the buffer position takes that descriptor's buf before any of its data is sent.
- R7: After a descriptor whose end-of-list bit is set, the channel stalls in state 2 and moves no data until it receives a command.
- R8: A continue command (command bit 1) given while stalled re-reads the descriptor at the descriptor pointer. If the end-of-list bit is still set, the channel stays stalled. If it is clear, the channel follows that descriptor's next pointer as in R6 and runs. A continue given while idle is ignored.
- R9: Completing a descriptor whose flags bit 3 is set sets bit 2 of the raw interrupt register.
- R10: The masked interrupt register equals the raw interrupt register ANDed with the mask. `irq` is high exactly when the masked value is non-zero.
- R11: Writing 1 to a bit of the acknowledge register clears that raw interrupt bit. If an interrupt sets the same bit in the same cycle, the bit stays set.
- R12: The descriptor pointer and buffer position registers accept writes only while the channel is idle or stalled. While it runs (state 1) such writes are dropped.
- R13: Once `mem_req` is raised, it stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after read |
| reg_err | output | 1 | Illegal-size access flag, one cycle after access |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transaction done; read data valid |
| mem_rdata | input | 32 | Memory read data |
| st_valid | output | 1 | Stream beat valid |
| st_ready | input | 1 | Stream sink ready |
| st_data | output | 8 | Stream byte |
| st_last | output | 1 | End of packet on this beat |
| irq | output | 1 | Interrupt request |

## Verification
The bench starts the first descriptor at a buffer position offset from its buf. A design that counted from buf rather than from the register would send extra bytes. Chains include zero-length and negative-length descriptors, which catch a design that underflows the count and streams the whole address space. Stream back-pressure is randomised, and one run holds the sink stalled while software tries to move the pointers, which exposes lost or duplicated bytes and pointer corruption. A directed continue sequence first leaves end-of-list set, then clears it. A design that resumed without re-reading the descriptor, or that kept the old buffer position, would send the wrong bytes or send them too early.

// File: rtl/dmaout_pkg.sv
package dmaout_pkg;
  localparam int DATA_W     = 32;
  localparam int DESC_WORDS = 4;
  localparam int IRQ_W      = 8;
  localparam int IRQ_DESC   = 2;

  localparam logic [7:0] OFS_DESC  = 8'h58;
  localparam logic [7:0] OFS_BUF   = 8'h5C;
  localparam logic [7:0] OFS_CMD   = 8'h80;
  localparam logic [7:0] OFS_STAT  = 8'h88;
  localparam logic [7:0] OFS_MASK  = 8'h8C;
  localparam logic [7:0] OFS_ACK   = 8'h90;
  localparam logic [7:0] OFS_RAW   = 8'h94;
  localparam logic [7:0] OFS_MSKD  = 8'h98;

  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam int CMD_START = 0;
  localparam int CMD_CONT  = 1;
  localparam int CMD_CTX   = 2;

  localparam int FL_EOL  = 0;
  localparam int FL_INTR = 3;
  localparam int FL_OEOP = 4;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_RUN   = 2'd1,
    CH_STALL = 2'd2
  } chan_state_e;

  typedef enum logic [2:0] {
    E_IDLE, E_FETCH, E_DECIDE, E_LOAD, E_SEND, E_WBACK, E_STALL
  } eng_state_e;

  typedef enum logic [1:0] {
    K_START, K_NEXT, K_CONT
  } fetch_kind_e;
endpackage

// File: rtl/dmaout_irq.sv
module dmaout_irq
  import dmaout_pkg::*;
#(
  parameter int IW = IRQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_wr,
  input  logic [IW-1:0] mask_wdata,
  input  logic [IW-1:0] ack_vec,
  input  logic [IW-1:0] set_vec,
  output logic [IW-1:0] raw_o,
  output logic [IW-1:0] mask_o,
  output logic [IW-1:0] masked_o,
  output logic          irq_o
);
  logic [IW-1:0] raw_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      raw_q <= (raw_q & ~ack_vec) | set_vec;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[IRQ_DESC] |=> raw_o[IRQ_DESC]);

  // R11
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec[IRQ_DESC] && !set_vec[IRQ_DESC]) |=> !raw_o[IRQ_DESC]);
endmodule

// File: rtl/dmaout_engine.sv
module dmaout_engine
  import dmaout_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_cont,
  input  logic              desc_wr,
  input  logic              buf_wr,
  input  logic [AW-1:0]     ptr_wdata,
  output logic [AW-1:0]     desc_ptr_o,
  output logic [AW-1:0]     buf_ptr_o,
  output chan_state_e       chan_state,
  output logic              desc_intr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [7:0]        st_data,
  output logic              st_last
);
  localparam int IDX_W  = $clog2(DESC_WORDS);
  localparam int LANE_W = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  eng_state_e  st;
  fetch_kind_e kind;
  logic [IDX_W-1:0] idx;
  logic [DESC_WORDS-1:0][DATA_W-1:0] dw;
  logic [DATA_W-1:0] word_q;
  logic [AW-1:0] desc_ptr, buf_ptr;

  logic [AW-1:0] d_next, d_buf, d_after;
  logic [DATA_W-1:0] d_flags;
  logic [AW-1:0] buf_inc;
  logic final_byte, ctl_free;

  assign d_next     = dw[0][AW-1:0];
  assign d_buf      = dw[1][AW-1:0];
  assign d_flags    = dw[2];
  assign d_after    = dw[3][AW-1:0];
  assign buf_inc    = buf_ptr + AW'(1);
  assign final_byte = (buf_inc == d_after);
  assign ctl_free   = (st == E_IDLE) || (st == E_STALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= E_IDLE;
      kind     <= K_START;
      idx      <= '0;
      dw       <= '0;
      word_q   <= '0;
      desc_ptr <= '0;
      buf_ptr  <= '0;
    end else begin
      if (ctl_free && desc_wr) desc_ptr <= ptr_wdata;
      if (ctl_free && buf_wr)  buf_ptr  <= ptr_wdata;
      case (st)
        E_IDLE, E_STALL: begin
          if (cmd_start) begin
            kind <= K_START;
            idx  <= '0;
            st   <= E_FETCH;
          end else if (st == E_STALL && cmd_cont) begin
            kind <= K_CONT;
            idx  <= '0;
            st   <= E_FETCH;
          end
        end
        E_FETCH: begin
          if (mem_ack) begin
            dw[idx] <= mem_rdata;
            idx     <= idx + 1'b1;
            if (idx == IDX_LAST) st <= E_DECIDE;
          end
        end
        E_DECIDE: begin
          case (kind)
            K_START: begin
              idx <= '0;
              st  <= (buf_ptr < d_after) ? E_LOAD : E_WBACK;
            end
            K_NEXT: begin
              buf_ptr <= d_buf;
              kind    <= K_START;
            end
            default: begin
              if (!d_flags[FL_EOL]) begin
                desc_ptr <= d_next;
                kind     <= K_NEXT;
                idx      <= '0;
                st       <= E_FETCH;
              end else begin
                st <= E_STALL;
              end
            end
          endcase
        end
        E_LOAD: begin
          if (mem_ack) begin
            word_q <= mem_rdata;
            st     <= E_SEND;
          end
        end
        E_SEND: begin
          if (st_ready) begin
            buf_ptr <= buf_inc;
            if (final_byte) begin
              idx <= '0;
              st  <= E_WBACK;
            end else if (buf_inc[LANE_W-1:0] == '0) begin
              st <= E_LOAD;
            end
          end
        end
        E_WBACK: begin
          if (mem_ack) begin
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) begin
              if (d_flags[FL_EOL]) begin
                st <= E_STALL;
              end else begin
                desc_ptr <= d_next;
                kind     <= K_NEXT;
                st       <= E_FETCH;
              end
            end
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == E_FETCH) || (st == E_LOAD) || (st == E_WBACK);
  assign mem_we    = (st == E_WBACK);
  assign mem_addr  = (st == E_LOAD) ? {buf_ptr[AW-1:LANE_W], LANE_W'(0)}
                                    : desc_ptr + AW'({idx, 2'b00});
  assign mem_wdata = dw[idx];

  assign st_valid  = (st == E_SEND);
  assign st_data   = word_q[{buf_ptr[LANE_W-1:0], 3'b000} +: 8];
  assign st_last   = final_byte && d_flags[FL_OEOP];

  assign desc_intr = (st == E_WBACK) && mem_ack && (idx == IDX_LAST) && d_flags[FL_INTR];

  assign desc_ptr_o = desc_ptr;
  assign buf_ptr_o  = buf_ptr;
  assign chan_state = (st == E_IDLE) ? CH_IDLE : (st == E_STALL) ? CH_STALL : CH_RUN;

  // R13
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_last)));

  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state == CH_STALL && !cmd_start && !cmd_cont) |=> (chan_state == CH_STALL && !st_valid));

  // R12
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && chan_state == CH_RUN && !st_ready && st_valid) |=> $stable(buf_ptr_o));
endmodule

// File: rtl/dmaout_chan.sv
module dmaout_chan
  import dmaout_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [7:0]        st_data,
  output logic              st_last,
  output logic              irq
);
  logic word_acc, wr_ok;
  logic cmd_wr, cmd_start, cmd_cont, desc_intr;
  logic [AW-1:0] desc_ptr, buf_ptr;
  logic [IRQ_W-1:0] ack_vec, set_vec, raw, mask, masked;
  chan_state_e chan_state;

  assign word_acc  = (reg_size == SIZE_WORD);
  assign wr_ok     = reg_wr && word_acc;
  assign cmd_wr    = wr_ok && (reg_addr == OFS_CMD);
  assign cmd_start = cmd_wr && reg_wdata[CMD_START];
  assign cmd_cont  = cmd_wr && reg_wdata[CMD_CONT];
  assign ack_vec   = (wr_ok && reg_addr == OFS_ACK) ? reg_wdata[IRQ_W-1:0] : '0;
  assign set_vec   = IRQ_W'(desc_intr) << IRQ_DESC;

  dmaout_engine #(.AW(AW)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .cmd_cont   (cmd_cont),
    .desc_wr    (wr_ok && reg_addr == OFS_DESC),
    .buf_wr     (wr_ok && reg_addr == OFS_BUF),
    .ptr_wdata  (reg_wdata[AW-1:0]),
    .desc_ptr_o (desc_ptr),
    .buf_ptr_o  (buf_ptr),
    .chan_state (chan_state),
    .desc_intr  (desc_intr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_data    (st_data),
    .st_last    (st_last)
  );

  dmaout_irq #(.IW(IRQ_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_wr    (wr_ok && reg_addr == OFS_MASK),
    .mask_wdata (reg_wdata[IRQ_W-1:0]),
    .ack_vec    (ack_vec),
    .set_vec    (set_vec),
    .raw_o      (raw),
    .mask_o     (mask),
    .masked_o   (masked),
    .irq_o      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      reg_err   <= 1'b0;
    end else begin
      reg_err   <= (reg_wr || reg_rd) && !word_acc;
      reg_rdata <= '0;
      if (reg_rd && word_acc) begin
        case (reg_addr)
          OFS_DESC: reg_rdata <= 32'(desc_ptr);
          OFS_BUF:  reg_rdata <= 32'(buf_ptr);
          OFS_STAT: reg_rdata <= 32'(chan_state);
          OFS_MASK: reg_rdata <= 32'(mask);
          OFS_RAW:  reg_rdata <= 32'(raw);
          OFS_MSKD: reg_rdata <= 32'(masked);
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end

  // R1
  size_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_size != SIZE_WORD) |=> reg_err);

  // R2
  ctx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && reg_wdata[2:0] == 3'b100 && chan_state == CH_IDLE) |=> (chan_state == CH_IDLE && !mem_req));

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec == '0 && !desc_intr && !(wr_ok && reg_addr == OFS_MASK)) |=> $stable(irq));
endmodule

// File: tb/dmaout_chan_bench.sv
module dmaout_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_err;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        st_valid, st_ready, st_last;
  logic [7:0]  st_data;
  logic        irq;

  always #2.5 clk = ~clk;

  dmaout_chan u_dmaout_chan (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .st_valid(st_valid), .st_ready(st_ready),
    .st_data(st_data), .st_last(st_last), .irq(irq)
  );

  logic [31:0] mem [0:255];
  int          wb_cnt [0:255];
  logic [31:0] wb_val [0:255];
  logic [7:0]  got_data [0:4095];
  logic        got_last [0:4095];
  int          got_n = 0;
  int          req_n = 0;
  logic        hold_ready = 1'b0;
  logic [7:0]  exp_data [0:1023];
  logic        exp_last [0:1023];
  int          exp_n;
  int          checks = 0;
  int          errors = 0;

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(negedge clk) begin
    if (!rst_n) begin
      st_ready = 1'b0;
      mem_ack  = 1'b0;
    end else begin
      st_ready = hold_ready ? 1'b0 : ($urandom_range(3) != 0);
      if (st_valid && st_ready) begin
        got_data[got_n] = st_data;
        got_last[got_n] = st_last;
        got_n++;
      end
      mem_ack = mem_req && ($urandom_range(2) != 0);
      if (mem_req && mem_ack && mem_we) begin
        wb_cnt[mem_addr[9:2]]++;
        wb_val[mem_addr[9:2]] = mem_wdata;
      end
      if (mem_req) req_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz, output logic err);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_size = sz; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_size = 2'd2;
    err = reg_err;
  endtask

  task automatic wrw(input logic [7:0] a, input logic [31:0] d);
    logic e;
    wr(a, d, 2'd2, e);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_size = 2'd2; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_state(input logic [31:0] want, input string tag);
    logic [31:0] v = 0;
    for (int t = 0; t < 3000; t++) begin
      rd(8'h88, v);
      if (v == want) break;
    end
    chk(tag, v, want);
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return mem[a[9:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic put_desc(input int w, input logic [31:0] nx, input logic [31:0] bp,
                          input logic [31:0] fl, input logic [31:0] af);
    mem[w] = nx; mem[w+1] = bp; mem[w+2] = fl; mem[w+3] = af;
  endtask

  task automatic expect_bytes(input logic [31:0] s, input logic [31:0] af, input logic oeop);
    for (logic [31:0] a = s; a < af; a++) begin
      exp_data[exp_n] = mem_byte(a);
      exp_last[exp_n] = oeop && (a == af - 1);
      exp_n++;
    end
  endtask

  task automatic cmp_stream(input int base, input string tag);
    chk({tag, " R3 byte count"}, 32'(got_n - base), 32'(exp_n));
    for (int k = 0; k < exp_n && k < got_n - base; k++) begin
      chk({tag, " R3 byte value"}, 32'(got_data[base+k]), 32'(exp_data[k]));
      chk({tag, " R4 last flag"}, 32'(got_last[base+k]), 32'(exp_last[k]));
    end
  endtask

  task automatic run_chain(input int n, input int iter);
    logic [31:0] bp, af, fl, s0, bufreg, mask, v;
    logic        any_intr;
    int          base, snap [0:15];
    exp_n = 0; any_intr = 0; bufreg = 0; s0 = 0; af = 0;
    mask = ($urandom_range(1) != 0) ? 32'h4 : 32'h0;
    for (int i = 0; i < n; i++) begin
      bp = 32'h200 + $urandom_range(32'h1BF);
      case ($urandom_range(5))
        0: af = bp;
        1: af = bp - 32'd3;
        default: af = bp + $urandom_range(12);
      endcase
      fl = {16'($urandom), 11'd0, 1'($urandom_range(1)), 1'($urandom_range(1)), 2'b00, 1'(i == n - 1)};
      put_desc(4 * i, 32'(16 * (i + 1)), bp, fl, af);
      if (i == 0) begin
        bufreg = bp + $urandom_range(2);
        s0 = bufreg;
      end else s0 = bp;
      expect_bytes(s0, af, fl[4]);
      if (fl[3]) any_intr = 1;
    end
    for (int w = 0; w < 16; w++) snap[w] = wb_cnt[w];
    wrw(8'h8C, mask);
    wrw(8'h58, 32'h0);
    wrw(8'h5C, bufreg);
    base = got_n;
    wrw(8'h80, 32'h1);
    wait_state(32'd2, $sformatf("chain %0d R7 stall state", iter));
    cmp_stream(base, $sformatf("chain %0d", iter));
    for (int w = 0; w < 4 * n; w++) begin
      chk($sformatf("chain %0d R5 writeback count", iter), 32'(wb_cnt[w] - snap[w]), 32'd1);
      chk($sformatf("chain %0d R5 writeback data", iter), wb_val[w], mem[w]);
    end
    rd(8'h58, v);
    chk($sformatf("chain %0d R6 descriptor pointer", iter), v, 32'(16 * (n - 1)));
    rd(8'h5C, v);
    chk($sformatf("chain %0d R3 final buffer position", iter), v, (s0 < af) ? af : s0);
    rd(8'h94, v);
    chk($sformatf("chain %0d R9 raw interrupt", iter), v, any_intr ? 32'h4 : 32'h0);
    rd(8'h98, v);
    chk($sformatf("chain %0d R10 masked interrupt", iter), v, (any_intr ? 32'h4 : 32'h0) & mask);
    chk($sformatf("chain %0d R10 irq pin", iter), 32'(irq), 32'(any_intr && mask[2]));
    base = got_n;
    repeat (20) @(negedge clk);
    chk($sformatf("chain %0d R7 no data while stalled", iter), 32'(got_n - base), 32'd0);
    wrw(8'h90, 32'h4);
    rd(8'h94, v);
    chk($sformatf("chain %0d R11 acknowledge clears", iter), v, 32'h0);
    chk($sformatf("chain %0d R10 irq after ack", iter), 32'(irq), 32'd0);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        e;
    int          base, rq;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = $urandom;
      wb_cnt[i] = 0;
      wb_val[i] = 0;
    end
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_size = 2'd2; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("reset stream idle", 32'(st_valid), 32'd0);
    chk("reset irq low", 32'(irq), 32'd0);
    chk("reset no memory request", 32'(mem_req), 32'd0);
    rd(8'h88, v);
    chk("reset state idle", v, 32'd0);

    wr(8'h8C, 32'h4, 2'd1, e);
    chk("R1 narrow write flags error", 32'(e), 32'd1);
    rd(8'h8C, v);
    chk("R1 narrow write has no effect", v, 32'h0);
    wr(8'h8C, 32'h4, 2'd2, e);
    chk("R1 word write no error", 32'(e), 32'd0);
    rd(8'h8C, v);
    chk("R1 word write lands", v, 32'h4);
    rd(8'h60, v);
    chk("R1 unlisted offset reads zero", v, 32'h0);

    rq = req_n;
    wrw(8'h80, 32'h4);
    repeat (10) @(negedge clk);
    rd(8'h88, v);
    chk("R2 load-context alone stays idle", v, 32'd0);
    chk("R2 load-context makes no memory request", 32'(req_n - rq), 32'd0);
    wrw(8'h80, 32'h2);
    repeat (10) @(negedge clk);
    rd(8'h88, v);
    chk("R8 continue while idle ignored", v, 32'd0);

    for (int it = 0; it < 8; it++) run_chain(1 + $urandom_range(2), it);

    // continue sequence
    put_desc(0, 32'h40, 32'h240, 32'h0000_0011, 32'h244);
    exp_n = 0;
    wrw(8'h58, 32'h0);
    wrw(8'h5C, 32'h240);
    base = got_n;
    wrw(8'h80, 32'h1);
    wait_state(32'd2, "R2 single descriptor stall");
    expect_bytes(32'h240, 32'h244, 1'b1);
    cmp_stream(base, "single");
    base = got_n;
    wrw(8'h80, 32'h2);
    repeat (40) @(negedge clk);
    rd(8'h88, v);
    chk("R8 continue with end-of-list still set stays stalled", v, 32'd2);
    chk("R8 no data after refused continue", 32'(got_n - base), 32'd0);
    put_desc(0, 32'h80, 32'h240, 32'h0000_0010, 32'h244);
    put_desc(32, 32'h0, 32'h301, 32'h0000_0019, 32'h307);
    exp_n = 0;
    expect_bytes(32'h301, 32'h307, 1'b1);
    base = got_n;
    wrw(8'h80, 32'h2);
    wait_state(32'd2, "R8 resumed chain stalls again");
    cmp_stream(base, "resume R8");
    rd(8'h58, v);
    chk("R8 descriptor pointer followed next", v, 32'h80);
    rd(8'h5C, v);
    chk("R6 buffer position from new buf", v, 32'h307);
    rd(8'h94, v);
    chk("R9 interrupt from resumed descriptor", v, 32'h4);
    wrw(8'h90, 32'h4);

    // pointer writes while running
    put_desc(0, 32'h0, 32'h280, 32'h0000_0001, 32'h288);
    wrw(8'h58, 32'h0);
    wrw(8'h5C, 32'h280);
    hold_ready = 1'b1;
    wrw(8'h80, 32'h1);
    repeat (30) @(negedge clk);
    rd(8'h88, v);
    chk("R12 channel running under back-pressure", v, 32'd1);
    wrw(8'h58, 32'h3F0);
    wrw(8'h5C, 32'h3F0);
    rd(8'h58, v);
    chk("R12 descriptor pointer write dropped while running", v, 32'h0);
    rd(8'h5C, v);
    chk("R12 buffer position write dropped while running", v, 32'h280);
    exp_n = 0;
    expect_bytes(32'h280, 32'h288, 1'b0);
    base = got_n;
    hold_ready = 1'b0;
    wait_state(32'd2, "R12 run completes");
    cmp_stream(base, "held R4");
    wrw(8'h58, 32'h40);
    rd(8'h58, v);
    chk("R12 descriptor pointer writable when stalled", v, 32'h40);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule